// File: doc/BRIEF.md
# Chained Dual-Channel Timer Counter

This block holds two up-counting channels behind a simple register bus. Each channel picks a count source (the block clock or the rising edges of an external clock line) and, in waveform mode, drives an output line that its two compare values can set, clear or toggle. The external clock line of channel 1 can be taken from channel 0's output. With channel 0 setting its output just after each wrap and clearing it at mid-range, channel 1 counts the wraps of channel 0. The two channels then act as a single monotonic counter twice as wide.

Software programs both channels, enables their clocks and issues a block-wide sync that zeroes both counters on the same edge. It then reads the upper half, the lower half and the upper half again, and repeats the sequence if the two upper reads differ. Mode, compare and routing registers are locked after reset. A key write unlocks them. Reads are combinational, and a write takes effect at the next clock edge.

Top module: `chained_tc`

## Requirements
- R1: After reset both counters read 0 and stay at 0 until started, both waveform outputs are low, and the protect register at 0xE4 reads 1 (locked).
- R2: Writing 1 to bit 0 of a channel's clock-control register (channel base + 0x00) enables that channel. With clock select 0 its counter then rises by one every block clock.
- R3: A counter wraps from all ones to 0. A match on the C compare value never restarts it, and the counter register (base + 0x10) always reads the live count.
- R4: Mode register (base + 0x04) bit 15 enables waveform mode. Bits 17:16 give the action when the count arrives at compare A (base + 0x14), and bits 19:18 give the action at compare C (base + 0x1C). The action codes are 0 none, 1 set, 2 clear and 3 toggle. The action applies on the edge where the counter takes that value, and C wins when A equals C. With bit 15 clear the output holds.
- R5: Mode bits 2:0 select the count source: 0 is the block clock, 6 is rising edges of the channel's external clock line, and any other code holds the counter.
- R6: Bits 3:2 of the routing register at 0xC4 equal to 2 connect channel 0's output to channel 1's external clock line, so that channel 1 steps on the same edge that channel 0's output rises. Any other value holds that line low.
- R7: Writing 1 to bit 0 at 0xC0 zeroes both counters and both outputs on one edge, and enabled channels keep counting.
- R8: With compare A = 1, compare C = half range, set on A and clear on C, channel 1 reads ceil(n / 2^W) n cycles after a sync. A high-low-high read that is retried when the two high reads differ never yields a smaller combined value.
- R9: A write to 0xE4 takes effect only when bits 31:8 equal 0x54494D. Bit 0 then becomes the new lock state. A write with any other key is ignored.
- R10: While locked, writes to the mode, compare A, compare C and routing registers are dropped. Clock-control, sync and interrupt-disable writes are always accepted.
- R11: Channel c's registers sit at c × 0x40. Mode, compare A, compare C and routing read back what was written. Clock-control and interrupt-disable (base + 0x28) read 0, and an interrupt-disable write does not disturb counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| tioa0 | output | 1 | Channel 0 waveform output |
| tioa1 | output | 1 | Channel 1 waveform output |

## Verification
The counting path is tried in three ways. A free-running channel with C placed inside the count range tells wrapping apart from restart on match. The chained setup, read cycle by cycle across several wraps with the retrying high-low-high sequence, tells a correctly timed carry from one that lags the low-half wrap. Seeded random compare values, action codes and mode bits, including A equal to C, separate the priority rule and the waveform-mode gate from plain set and clear behaviour. Wrong-key and right-key writes, with locked and unlocked register writes between them, show which writes the lock drops.

// File: rtl/ctmr_pkg.sv
`timescale 1ns/1ps
package ctmr_pkg;
  // per-channel register offsets inside a 0x40 window
  localparam logic [5:0] OFS_CCR = 6'h00;
  localparam logic [5:0] OFS_CMR = 6'h04;
  localparam logic [5:0] OFS_CV  = 6'h10;
  localparam logic [5:0] OFS_RA  = 6'h14;
  localparam logic [5:0] OFS_RC  = 6'h1C;
  localparam logic [5:0] OFS_IDR = 6'h28;

  localparam logic [7:0] ADR_SYNC = 8'hC0;
  localparam logic [7:0] ADR_ROUTE = 8'hC4;
  localparam logic [7:0] ADR_LOCK = 8'hE4;

  localparam logic [23:0] UNLOCK_KEY = 24'h54494D;

  localparam logic [2:0] CKSEL_INT = 3'd0;
  localparam logic [2:0] CKSEL_EXT = 3'd6;
  localparam logic [1:0] ROUTE_FROM_CH0 = 2'd2;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TGL  = 2'd3
  } out_act_e;

  typedef struct packed {
    out_act_e   c_act;
    out_act_e   a_act;
    logic       wave;
    logic [2:0] clk_sel;
  } chan_mode_t;

  function automatic logic apply_act(input out_act_e act, input logic cur);
    case (act)
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      ACT_TGL: return ~cur;
      default: return cur;
    endcase
  endfunction
endpackage

// File: rtl/ctmr_wprot.sv
`timescale 1ns/1ps
module ctmr_wprot
  import ctmr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lock,
  input  logic [31:0] wdata,
  output logic        locked
);
  logic lock_q;
  logic lock_d;
  logic key_ok;

  assign key_ok = (wdata[31:8] == UNLOCK_KEY);

  always_comb begin
    lock_d = lock_q;
    if (wr_lock && key_ok) lock_d = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b1;
    else        lock_q <= lock_d;
  end

  assign locked = lock_q;

  assert_bad_key_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lock && (wdata[31:8] != UNLOCK_KEY)) |=> $stable(locked));
endmodule

// File: rtl/ctmr_chan.sv
`timescale 1ns/1ps
module ctmr_chan
  import ctmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             sync,
  input  logic             wr_mode,
  input  logic             wr_ra,
  input  logic             wr_rc,
  input  logic [31:0]      wdata,
  input  logic             xc_in,
  output logic [CNT_W-1:0] cv,
  output logic [CNT_W-1:0] ra,
  output logic [CNT_W-1:0] rc,
  output chan_mode_t       mode,
  output logic             tioa,
  output logic             tioa_nxt
);
  logic             clken_q, clken_d;
  logic             xc_q;
  chan_mode_t       mode_q;
  logic [CNT_W-1:0] ra_q, rc_q, cv_q, cv_d, cv_inc;
  logic             tioa_q, tioa_d;
  logic             tick, cnt_en;

  always_comb begin
    tick = 1'b0;
    if (mode_q.clk_sel == CKSEL_INT)      tick = 1'b1;
    else if (mode_q.clk_sel == CKSEL_EXT) tick = xc_in & ~xc_q;
    cnt_en  = clken_q & tick;
    cv_inc  = cv_q + CNT_W'(1);
    clken_d = clken_q | start;
    cv_d    = cv_q;
    tioa_d  = tioa_q;
    if (sync) begin
      cv_d   = '0;
      tioa_d = 1'b0;
    end else if (cnt_en) begin
      cv_d = cv_inc;
      if (mode_q.wave) begin
        if (cv_inc == rc_q)      tioa_d = apply_act(mode_q.c_act, tioa_q);
        else if (cv_inc == ra_q) tioa_d = apply_act(mode_q.a_act, tioa_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clken_q <= 1'b0;
      xc_q    <= 1'b0;
      cv_q    <= '0;
      tioa_q  <= 1'b0;
      mode_q  <= '0;
      ra_q    <= '0;
      rc_q    <= '0;
    end else begin
      clken_q <= clken_d;
      xc_q    <= xc_in;
      cv_q    <= cv_d;
      tioa_q  <= tioa_d;
      if (wr_mode) begin
        mode_q.c_act   <= out_act_e'(wdata[19:18]);
        mode_q.a_act   <= out_act_e'(wdata[17:16]);
        mode_q.wave    <= wdata[15];
        mode_q.clk_sel <= wdata[2:0];
      end
      if (wr_ra) ra_q <= wdata[CNT_W-1:0];
      if (wr_rc) rc_q <= wdata[CNT_W-1:0];
    end
  end

  assign cv       = cv_q;
  assign ra       = ra_q;
  assign rc       = rc_q;
  assign mode     = mode_q;
  assign tioa     = tioa_q;
  assign tioa_nxt = tioa_d;

  assert_stopped_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clken_q && !sync) |=> $stable(cv_q));
  assert_wave_off_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q.wave && !sync) |=> $stable(tioa_q));
  assert_sync_zeroes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> (cv_q == '0 && !tioa_q));
endmodule

// File: rtl/chained_tc.sv
`timescale 1ns/1ps
module chained_tc
  import ctmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int N_CH  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        tioa0,
  output logic        tioa1
);
  localparam int CH_SEL_W = 2;

  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic             locked;
  logic             sync_cmd;
  logic [1:0]       route_q, route_d;
  logic             xc1_route;
  logic [N_CH-1:0]  tioa_v, tioa_nxt_v;
  logic [CNT_W-1:0] cv_v [N_CH];
  logic [CNT_W-1:0] ra_v [N_CH];
  logic [CNT_W-1:0] rc_v [N_CH];
  chan_mode_t       mode_v [N_CH];
  logic             unused_tioa_nxt;
  logic [31:0]      rdata_d;

  // reset: asserted at once, released two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign sync_cmd = bus_we && (bus_addr == ADR_SYNC) && bus_wdata[0];

  ctmr_wprot u_wprot (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .wr_lock(bus_we && (bus_addr == ADR_LOCK)),
    .wdata  (bus_wdata),
    .locked (locked)
  );

  always_comb begin
    route_d = route_q;
    if (bus_we && (bus_addr == ADR_ROUTE) && !locked) route_d = bus_wdata[3:2];
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) route_q <= 2'b00;
    else             route_q <= route_d;
  end

  // look-ahead link: channel 1 sees channel 0's next output value
  assign xc1_route = (route_q == ROUTE_FROM_CH0) & tioa_nxt_v[0];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic hit;
    logic xc;
    assign hit = bus_we && (bus_addr[7:6] == CH_SEL_W'(c));
    if (c == 1) begin : g_link
      assign xc = xc1_route;
    end else begin : g_nolink
      assign xc = 1'b0;
    end

    ctmr_chan #(.CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .start   (hit && (bus_addr[5:0] == OFS_CCR) && bus_wdata[0]),
      .sync    (sync_cmd),
      .wr_mode (hit && (bus_addr[5:0] == OFS_CMR) && !locked),
      .wr_ra   (hit && (bus_addr[5:0] == OFS_RA) && !locked),
      .wr_rc   (hit && (bus_addr[5:0] == OFS_RC) && !locked),
      .wdata   (bus_wdata),
      .xc_in   (xc),
      .cv      (cv_v[c]),
      .ra      (ra_v[c]),
      .rc      (rc_v[c]),
      .mode    (mode_v[c]),
      .tioa    (tioa_v[c]),
      .tioa_nxt(tioa_nxt_v[c])
    );

    assert_locked_mode_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
      (locked && bus_we && (bus_addr == {CH_SEL_W'(c), OFS_CMR})) |=> $stable(mode_v[c]));
  end

  assign unused_tioa_nxt = tioa_nxt_v[N_CH-1];

  always_comb begin
    rdata_d = '0;
    if (bus_addr == ADR_ROUTE)     rdata_d = {28'd0, route_q, 2'b00};
    else if (bus_addr == ADR_LOCK) rdata_d = {31'd0, locked};
    else begin
      for (int c = 0; c < N_CH; c++) begin
        if (bus_addr[7:6] == CH_SEL_W'(c)) begin
          case (bus_addr[5:0])
            OFS_CMR: rdata_d = {12'd0, mode_v[c].c_act, mode_v[c].a_act, mode_v[c].wave,
                                12'd0, mode_v[c].clk_sel};
            OFS_CV:  rdata_d = 32'(cv_v[c]);
            OFS_RA:  rdata_d = 32'(ra_v[c]);
            OFS_RC:  rdata_d = 32'(rc_v[c]);
            default: rdata_d = '0;
          endcase
        end
      end
    end
  end

  assign bus_rdata = rdata_d;
  assign tioa0     = tioa_v[0];
  assign tioa1     = tioa_v[1];

  assert_locked_route_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (locked && bus_we && (bus_addr == ADR_ROUTE)) |=> $stable(route_q));
  assert_unrouted_holds_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((route_q != ROUTE_FROM_CH0) && (mode_v[1].clk_sel == CKSEL_EXT) && !sync_cmd)
      |=> $stable(cv_v[1]));
endmodule

// File: tb/tb_chained_tc.sv
`timescale 1ns/1ps
module tb_chained_tc;
  localparam int W = 12;
  localparam int unsigned RANGE = 1 << W;
  localparam logic [7:0] A_CCR0 = 8'h00, A_CMR0 = 8'h04, A_CV0 = 8'h10, A_RA0 = 8'h14,
                         A_RC0 = 8'h1C, A_IDR0 = 8'h28, A_CCR1 = 8'h40, A_CMR1 = 8'h44,
                         A_CV1 = 8'h50, A_SYNC = 8'hC0, A_ROUTE = 8'hC4, A_LOCK = 8'hE4;
  localparam logic [31:0] KEY = 32'h54494D00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic tioa0, tioa1;

  int unsigned cyc = 0;
  int unsigned sync_base = 0;
  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  // model state for the random compare trials
  int unsigned m_n;
  logic m_t;
  int unsigned m_r;
  int unsigned m_ra, m_rc;
  logic [1:0] m_aa, m_ca;
  logic m_wave;

  chained_tc #(.CNT_W(W), .N_CH(2)) dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tioa0(tioa0), .tioa1(tioa1)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int unsigned nn();
    return cyc - sync_base;
  endfunction
  function automatic int unsigned exp_lo(input int unsigned n);
    return n % RANGE;
  endfunction
  function automatic int unsigned exp_hi(input int unsigned n);
    return (n + RANGE - 1) / RANGE;
  endfunction
  function automatic logic exp_out(input int unsigned n);
    return (exp_lo(n) >= 1) && (exp_lo(n) < RANGE / 2);
  endfunction
  function automatic logic act_fn(input logic [1:0] a, input logic cur);
    case (a)
      2'd1: return 1'b1;
      2'd2: return 1'b0;
      2'd3: return ~cur;
      default: return cur;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd_now(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5 d = bus_rdata;
  endtask

  task automatic do_sync();
    @(negedge clk);
    bus_we = 1'b1; bus_addr = A_SYNC; bus_wdata = 32'h1;
    sync_base = cyc + 1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic step_model();
    logic old;
    int unsigned v;
    old = m_t;
    m_n++;
    v = m_n % RANGE;
    if (m_wave) begin
      if (v == m_rc)      m_t = act_fn(m_ca, m_t);
      else if (v == m_ra) m_t = act_fn(m_aa, m_t);
    end
    if (!old && m_t) m_r++;
  endtask

  task automatic trial(input int unsigned ra, input int unsigned rc, input logic [1:0] aa,
                       input logic [1:0] ca, input logic wave);
    logic [31:0] d;
    m_ra = ra; m_rc = rc; m_aa = aa; m_ca = ca; m_wave = wave;
    wr(A_CMR0, {12'd0, ca, aa, wave, 15'd0});
    wr(A_RA0, ra);
    wr(A_RC0, rc);
    do_sync();
    m_n = 0; m_t = 1'b0; m_r = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      #1;
      step_model();
      chk("R4 output after compare action", {31'd0, tioa0}, {31'd0, m_t});
    end
    @(negedge clk);
    step_model();
    rd_now(A_CV1, d);
    chk("R6 upper channel counts output rises", d, m_r);
    rd_now(A_CV0, d);
    chk("R2 lower channel count", d, exp_lo(m_n));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all R): actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2, h1, h3, lo;
    logic [63:0] prev, val;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(A_CV0, d);  chk("R1 counter 0 after reset", d, 0);
    rd(A_CV1, d);  chk("R1 counter 1 after reset", d, 0);
    rd(A_LOCK, d); chk("R1 lock after reset", d, 1);
    chk("R1 outputs low", {30'd0, tioa1, tioa0}, 0);
    repeat (6) @(negedge clk);
    rd(A_CV0, d);  chk("R1 counter idle before start", d, 0);

    // R10 locked writes dropped, R9 key handling
    wr(A_RA0, 32'h5);
    rd(A_RA0, d);  chk("R10 compare A write dropped while locked", d, 0);
    wr(A_ROUTE, 32'h8);
    rd(A_ROUTE, d); chk("R10 routing write dropped while locked", d, 0);
    wr(A_CMR0, 32'h8000);
    rd(A_CMR0, d); chk("R10 mode write dropped while locked", d, 0);
    wr(A_LOCK, 32'h12345600);
    rd(A_LOCK, d); chk("R9 wrong key ignored", d, 1);
    wr(A_LOCK, KEY);
    rd(A_LOCK, d); chk("R9 right key unlocks", d, 0);

    // R11 readback
    wr(A_RA0, 32'h5);
    rd(A_RA0, d);  chk("R11 compare A readback", d, 5);
    wr(A_RC0, 32'h10);
    rd(A_RC0, d);  chk("R11 compare C readback", d, 32'h10);
    wr(A_CMR0, 32'h000A8006);
    rd(A_CMR0, d); chk("R11 mode readback", d, 32'h000A8006);
    wr(A_CMR0, 32'h0);
    rd(A_CCR0, d); chk("R11 clock-control reads zero", d, 0);

    // R2/R3 free count, C match inside range
    wr(A_CCR0, 32'h1);
    do_sync();
    for (int k = 0; k < 25; k++) begin
      rd(A_CV0, d);
      chk("R2 R3 counter steps through C match", d, exp_lo(nn()));
    end
    wr(A_IDR0, 32'hFF);
    rd(A_IDR0, d); chk("R11 interrupt-disable reads zero", d, 0);
    rd(A_CV0, d);  chk("R11 counting undisturbed by interrupt-disable", d, exp_lo(nn()));
    while (nn() < RANGE - 4) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      rd(A_CV0, d);
      chk("R3 counter wraps", d, exp_lo(nn()));
    end

    // R5 other clock select holds
    wr(A_CMR0, 32'h3);
    rd(A_CV0, d);
    repeat (10) @(negedge clk);
    rd(A_CV0, d2);
    chk("R5 unused clock select holds", d2, d);
    wr(A_CMR0, 32'h0);

    // R6/R8 chained setup
    wr(A_CMR0, 32'h00098000);
    wr(A_RA0, 32'h1);
    wr(A_RC0, RANGE / 2);
    wr(A_CMR1, 32'h00008006);
    wr(A_ROUTE, 32'h8);
    wr(A_CCR1, 32'h1);
    do_sync();
    for (int k = 0; k < 6; k++) begin
      rd(A_CV0, d); chk("R7 R8 low half after sync", d, exp_lo(nn()));
      rd(A_CV1, d); chk("R7 R8 high half after sync", d, exp_hi(nn()));
      chk("R4 chained output", {31'd0, tioa0}, {31'd0, exp_out(nn())});
    end
    while (nn() < RANGE - 5) @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      rd(A_CV0, d); chk("R8 low half across wrap", d, exp_lo(nn()));
      rd(A_CV1, d); chk("R8 high half across wrap", d, exp_hi(nn()));
      chk("R4 chained output across wrap", {31'd0, tioa0}, {31'd0, exp_out(nn())});
    end

    // R8 retrying high-low-high reads across three wraps
    prev = 64'd0;
    while (nn() < 4 * RANGE) begin
      rd(A_CV1, h1);
      rd(A_CV0, lo);
      rd(A_CV1, h3);
      if (h1 == h3) begin
        val = {h1, lo[W-1:0]} ;
        val = 64'(h1) * RANGE + 64'(lo);
        vectors++;
        if (val < prev) begin
          fails++;
          $display("FAIL R8 combined value decreased: actual %h expected >= %h", val, prev);
        end
        prev = val;
      end
    end

    // R7 sync mid-run
    do_sync();
    rd(A_CV1, d); chk("R7 high half restarts", d, exp_hi(nn()));
    rd(A_CV0, d); chk("R7 low half restarts", d, exp_lo(nn()));

    // R6 unrouted line holds channel 1
    wr(A_ROUTE, 32'h0);
    rd(A_CV1, d);
    repeat (RANGE + 100) @(negedge clk);
    rd(A_CV1, d2);
    chk("R6 channel 1 holds without routing", d2, d);
    wr(A_ROUTE, 32'h8);

    // R4 directed priority and random compare configurations
    trial(40, 40, 2'd1, 2'd2, 1'b1);
    trial(30, 90, 2'd3, 2'd3, 1'b0);
    for (int t = 0; t < 28; t++) begin
      trial(1 + ($urandom % 400), 1 + ($urandom % 400), 2'($urandom % 4), 2'($urandom % 4),
            ($urandom % 4) != 0);
    end

    // R9/R10 relock
    wr(A_LOCK, KEY | 32'h1);
    rd(A_LOCK, d); chk("R9 right key relocks", d, 1);
    rd(A_RA0, d2);
    wr(A_RA0, d2 + 32'h7);
    rd(A_RA0, d);  chk("R10 compare A dropped after relock", d, d2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule